// File: doc/BRIEF.md
# Interrupt Vector Receive Status Register

This block keeps the receive status of a processor's incoming interrupt vector port. When a vector arrives from another module, hardware raises a busy flag and records the 5-bit identity of the sender. While the flag is up, later arrivals are refused with a same-cycle NACK so that the sender can retry, and the recorded identity stays put. Only privileged software can drop the flag, by writing a zero to it.

Software reaches the register through a simple read/write port that carries a privilege qualifier. An access made without privilege leaves the register untouched, reads back zero, and produces a one-cycle violation pulse that the trap logic elsewhere turns into an exception. The register image places the sender identity in the low bits, the busy flag directly above it, and zeros in every bit above that.

Top module: `ivr_recv_status`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the busy flag and the stored sender ID, so a privileged read afterwards returns zero.
- R2: An arrival (arr_valid high) while the busy flag is clear is accepted: from the next cycle the flag is set (register bit 5) and bits 4:0 hold the arriving ID.
- R3: An arrival while the busy flag is set, with no clear in that cycle, raises arr_nack in the same cycle and leaves the stored ID and the flag unchanged.
- R4: A privileged write with bit 5 of the write data at zero clears the busy flag from the next cycle; the stored ID is kept.
- R5: A privileged write with bit 5 at one has no effect on the flag, and the write data in bits 4:0 never changes the stored ID.
- R6: Register bits 63:6 always read as zero.
- R7: An access (read or write) with acc_priv low changes no state, returns zero read data, and raises priv_viol for exactly the following cycle.
- R8: When an arrival and a privileged clear fall in the same cycle, the arrival is accepted without NACK: the flag stays set and the new ID is captured.
- R9: Hardware never clears the busy flag; without a privileged clear it stays set.
- R10: A privileged read (acc_en high, acc_we low) returns the register image in the same cycle; in any other cycle acc_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arr_valid | input | 1 | An interrupt vector arrives this cycle |
| arr_id | input | 5 | Module ID of the sender |
| arr_nack | output | 1 | Arrival refused this cycle |
| acc_en | input | 1 | Register access this cycle |
| acc_we | input | 1 | Access is a write |
| acc_priv | input | 1 | Access is made with privilege |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data |
| priv_viol | output | 1 | One-cycle pulse after an unprivileged access |

## Verification
arr_nack and acc_rdata are combinational, so the bench drives inputs at the falling edge and compares them a nanosecond later in that same cycle against its model's present state. The flag, the ID and priv_viol change at the rising edge after the stimulus, so the model is advanced at that edge and priv_viol is compared shortly after it, while the new flag and ID are seen through the next cycle's read. Random cycles from a fixed seed are mixed with directed cases for reset, refusal, clearing, a write of one, the simultaneous arrival and clear, and unprivileged accesses.

// File: rtl/ivr_pkg.sv
`timescale 1ns/1ps
package ivr_pkg;

   localparam int unsigned IVR_DATA_W = 64;
   localparam int unsigned IVR_ID_W   = 5;

   // Decoded access intent for one cycle
   typedef struct packed {
      logic clr;      // privileged write with flag bit at zero
      logic rd_ok;    // privileged read
      logic unpriv;   // access without privilege
   } ivr_ctl_t;

endpackage

// File: rtl/ivr_access_decode.sv
`timescale 1ns/1ps
module ivr_access_decode
   import ivr_pkg::*;
#(
   parameter int unsigned DATA_W = IVR_DATA_W,
   parameter int unsigned ID_W   = IVR_ID_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc_en,
   input  logic              acc_we,
   input  logic              acc_priv,
   input  logic [DATA_W-1:0] acc_wdata,
   output ivr_ctl_t          ctl,
   output logic              priv_viol
);

   localparam int unsigned FLAG_POS = ID_W;

   initial begin
      assert (DATA_W > ID_W) else $fatal(1, "data width must exceed the ID width");
   end

   logic viol_q;
   logic unused_wdata;

   assign unused_wdata = ^acc_wdata;

   always_comb begin
      ctl.clr    = acc_en & acc_we & acc_priv & ~acc_wdata[FLAG_POS];
      ctl.rd_ok  = acc_en & ~acc_we & acc_priv;
      ctl.unpriv = acc_en & ~acc_priv;
   end

   always_ff @(posedge clk) begin
      if (rst) viol_q <= 1'b0;
      else     viol_q <= ctl.unpriv;
   end

   assign priv_viol = viol_q;

   // R7: an unprivileged access is reported on the next cycle
   assert_viol_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      (acc_en && !acc_priv) |=> priv_viol);
   // R7: no report without a preceding unprivileged access
   assert_viol_cause_R7: assert property (@(posedge clk) disable iff (rst)
      (!acc_en || acc_priv) |=> !priv_viol);

endmodule

// File: rtl/ivr_state.sv
`timescale 1ns/1ps
module ivr_state
   import ivr_pkg::*;
#(
   parameter int unsigned ID_W = IVR_ID_W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            arr_valid,
   input  logic [ID_W-1:0] arr_id,
   input  logic            clr,
   output logic            busy_q,
   output logic [ID_W-1:0] id_q,
   output logic            arr_nack
);

   initial begin
      assert (ID_W > 0) else $fatal(1, "ID width must be positive");
   end

   logic accept;

   // a clear in the same cycle frees the slot for the arrival
   assign accept   = arr_valid & (~busy_q | clr);
   assign arr_nack = arr_valid & ~accept;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         id_q   <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         id_q   <= arr_id;
      end else if (clr) begin
         busy_q <= 1'b0;
      end
   end

   // R1: reset empties the register
   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (!busy_q && id_q == '0));
   // R2: an accepted arrival sets the flag and captures the sender
   assert_accept_capture_R2: assert property (@(posedge clk) disable iff (rst)
      (arr_valid && !arr_nack) |=> (busy_q && id_q == $past(arr_id)));
   // R3: a refused arrival leaves the contents alone
   assert_nack_keeps_R3: assert property (@(posedge clk) disable iff (rst)
      arr_nack |=> (busy_q && $stable(id_q)));
   // R9: the flag only falls after a clear
   assert_busy_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (busy_q && !clr) |=> busy_q);
   // R4: the ID survives a clear
   assert_clear_keeps_id_R4: assert property (@(posedge clk) disable iff (rst)
      (clr && !arr_valid) |=> (!busy_q && $stable(id_q)));

endmodule

// File: rtl/ivr_read_mux.sv
`timescale 1ns/1ps
module ivr_read_mux
   import ivr_pkg::*;
#(
   parameter int unsigned DATA_W    = IVR_DATA_W,
   parameter int unsigned ID_W      = IVR_ID_W,
   parameter bit          GATE_READ = 1'b1
) (
   input  logic              rd_ok,
   input  logic              busy,
   input  logic [ID_W-1:0]   id,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned FLAG_POS = ID_W;

   logic [DATA_W-1:0] image;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      if (g < ID_W) begin : g_id
         assign image[g] = id[g];
      end else if (g == FLAG_POS) begin : g_flag
         assign image[g] = busy;
      end else begin : g_rsvd
         assign image[g] = 1'b0;
      end
   end

   if (GATE_READ) begin : g_gated
      assign rdata = rd_ok ? image : '0;
   end else begin : g_open
      logic unused_rd;
      assign unused_rd = rd_ok;
      assign rdata     = image;
   end

endmodule

// File: rtl/ivr_recv_status.sv
`timescale 1ns/1ps
module ivr_recv_status
   import ivr_pkg::*;
#(
   parameter int unsigned DATA_W = IVR_DATA_W,
   parameter int unsigned ID_W   = IVR_ID_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              arr_valid,
   input  logic [ID_W-1:0]   arr_id,
   output logic              arr_nack,
   input  logic              acc_en,
   input  logic              acc_we,
   input  logic              acc_priv,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              priv_viol
);

   localparam int unsigned FLAG_POS = ID_W;

   ivr_ctl_t        ctl;
   logic            busy_q;
   logic [ID_W-1:0] id_q;

   ivr_access_decode #(.DATA_W(DATA_W), .ID_W(ID_W)) u_dec (
      .clk      (clk),
      .rst      (rst),
      .acc_en   (acc_en),
      .acc_we   (acc_we),
      .acc_priv (acc_priv),
      .acc_wdata(acc_wdata),
      .ctl      (ctl),
      .priv_viol(priv_viol)
   );

   ivr_state #(.ID_W(ID_W)) u_state (
      .clk      (clk),
      .rst      (rst),
      .arr_valid(arr_valid),
      .arr_id   (arr_id),
      .clr      (ctl.clr),
      .busy_q   (busy_q),
      .id_q     (id_q),
      .arr_nack (arr_nack)
   );

   ivr_read_mux #(.DATA_W(DATA_W), .ID_W(ID_W), .GATE_READ(1'b1)) u_rd (
      .rd_ok(ctl.rd_ok),
      .busy (busy_q),
      .id   (id_q),
      .rdata(acc_rdata)
   );

   // R6: nothing above the flag is ever driven
   assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (acc_rdata >> (FLAG_POS + 1)) == '0);
   // R7: unprivileged access leaves the flag as it was
   assert_unpriv_no_change_R7: assert property (@(posedge clk) disable iff (rst)
      (acc_en && !acc_priv && !arr_valid) |=> $stable(busy_q));
   // R8: arrival meeting a clear is never refused
   assert_race_accept_R8: assert property (@(posedge clk) disable iff (rst)
      (arr_valid && acc_en && acc_we && acc_priv && !acc_wdata[FLAG_POS]) |-> !arr_nack);
   // R10: read data only during a privileged read
   assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
      !(acc_en && !acc_we && acc_priv) |-> acc_rdata == '0);

endmodule

// File: tb/ivr_recv_status_tb_top.sv
`timescale 1ns/1ps
module ivr_recv_status_tb_top;

   localparam int DW = 64;
   localparam int IW = 5;

   logic          clk = 1'b0;
   logic          rst;
   logic          arr_valid;
   logic [IW-1:0] arr_id;
   logic          arr_nack;
   logic          acc_en, acc_we, acc_priv;
   logic [DW-1:0] acc_wdata;
   logic [DW-1:0] acc_rdata;
   logic          priv_viol;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // model state
   logic          m_busy;
   logic [IW-1:0] m_id;

   always #5 clk = ~clk;

   ivr_recv_status dut_i (
      .clk(clk), .rst(rst),
      .arr_valid(arr_valid), .arr_id(arr_id), .arr_nack(arr_nack),
      .acc_en(acc_en), .acc_we(acc_we), .acc_priv(acc_priv),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .priv_viol(priv_viol)
   );

   function automatic logic [DW-1:0] exp_image(logic b, logic [IW-1:0] id);
      exp_image = '0;
      exp_image[IW-1:0] = id;
      exp_image[IW] = b;
   endfunction

   function automatic logic exp_clear(logic en, logic we, logic pr, logic [DW-1:0] wd);
      exp_clear = en & we & pr & ~wd[IW];
   endfunction

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle of stimulus with full comparison against the model
   task automatic step(logic av, logic [IW-1:0] aid, logic en, logic we,
                       logic pr, logic [DW-1:0] wd, string tag);
      logic clr, acc, nack, rd, viol;
      @(negedge clk);
      arr_valid = av; arr_id = aid;
      acc_en = en; acc_we = we; acc_priv = pr; acc_wdata = wd;
      clr  = exp_clear(en, we, pr, wd);
      acc  = av & (~m_busy | clr);
      nack = av & ~acc;
      rd   = en & ~we & pr;
      viol = en & ~pr;
      #1;
      check({tag, " R3 nack"}, {63'b0, arr_nack}, {63'b0, nack});
      check({tag, " R10 rdata"}, acc_rdata, rd ? exp_image(m_busy, m_id) : '0);
      @(posedge clk);
      if (acc) begin m_busy = 1'b1; m_id = aid; end
      else if (clr) m_busy = 1'b0;
      #1;
      check({tag, " R7 viol"}, {63'b0, priv_viol}, {63'b0, viol});
   endtask

   task automatic idle();
      step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "idle");
   endtask

   // privileged read of the current contents
   task automatic pread(string tag);
      step(1'b0, '0, 1'b1, 1'b0, 1'b1, '0, tag);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h5eed_1234);
      rst = 1'b1; arr_valid = 0; arr_id = '0;
      acc_en = 0; acc_we = 0; acc_priv = 0; acc_wdata = '0;
      m_busy = 1'b0; m_id = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;

      // R1: reset state
      pread("R1");
      check("R1 busy", {63'b0, m_busy}, 64'd0);

      // R2: arrival while free
      step(1'b1, 5'd19, 1'b0, 1'b0, 1'b0, '0, "R2");
      pread("R2");
      check("R2 read", acc_rdata, exp_image(1'b1, 5'd19));

      // R3: refused arrival, ID kept
      step(1'b1, 5'd7, 1'b0, 1'b0, 1'b0, '0, "R3");
      check("R3 nack", {63'b0, arr_nack}, 64'd1);
      pread("R3");
      check("R3 id kept", acc_rdata, exp_image(1'b1, 5'd19));

      // R5: write of one, ID field data ignored
      step(1'b0, '0, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFE0 | 64'h0A, "R5");
      pread("R5");
      check("R5 unchanged", acc_rdata, exp_image(1'b1, 5'd19));

      // R7: unprivileged clear attempt and read
      step(1'b0, '0, 1'b1, 1'b1, 1'b0, '0, "R7");
      check("R7 viol", {63'b0, priv_viol}, 64'd1);
      step(1'b0, '0, 1'b1, 1'b0, 1'b0, '0, "R7");
      check("R7 read zero", acc_rdata, 64'd0);
      pread("R7");
      check("R7 kept", acc_rdata, exp_image(1'b1, 5'd19));
      check("R7 pulse ends", {63'b0, priv_viol}, 64'd0);

      // R9: flag held over idle cycles
      repeat (5) idle();
      pread("R9");
      check("R9 sticky", acc_rdata, exp_image(1'b1, 5'd19));

      // R8: arrival and clear together
      step(1'b1, 5'd30, 1'b1, 1'b1, 1'b1, '0, "R8");
      pread("R8");
      check("R8 new id", acc_rdata, exp_image(1'b1, 5'd30));

      // R4: clear keeps ID
      step(1'b0, '0, 1'b1, 1'b1, 1'b1, 64'h1F, "R4");
      pread("R4");
      check("R4 cleared", acc_rdata, exp_image(1'b0, 5'd30));

      // R6: reserved bits under random traffic, plus model comparison
      for (int i = 0; i < 4000; i++) begin
         logic [DW-1:0] wd;
         wd = {$urandom, $urandom};
         step(($urandom % 3) == 0, IW'($urandom), ($urandom % 2) == 0,
              ($urandom % 2) == 0, ($urandom % 5) != 0, wd, "rand");
         check("R6 reserved", acc_rdata >> (IW + 1), 64'd0);
      end

      // R1: reset from a busy state
      step(1'b1, 5'd3, 1'b1, 1'b1, 1'b1, '0, "pre");
      @(negedge clk); rst = 1'b1; arr_valid = 0; acc_en = 0;
      @(posedge clk); m_busy = 1'b0; m_id = '0;
      @(negedge clk); rst = 1'b0;
      pread("R1");
      check("R1 after reset", acc_rdata, 64'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule